// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block is one DMA channel that walks a list of descriptors held in system memory. Software points the channel at the first descriptor and pulses a start strobe. For each descriptor the channel reads a link word, a command word and a buffer address. It then copies a number of setup words from the descriptor into consecutive registers of an attached peripheral. Finally it moves a block of data between the peripheral's data port and the buffer, in the direction the command word selects.

When a descriptor finishes, its command word decides what happens next. The channel can raise a sticky interrupt and decrement a semaphore. It can wait for the peripheral to signal the end of its command, and it can follow the link word to the next descriptor. A semaphore that reaches zero stalls a chained channel until software adds to it. A terminate input cuts the current descriptor short. A per-descriptor flag chooses whether the channel then halts outright or finishes the descriptor normally.

Memory is a word-addressed port whose read data is valid in the same cycle as the request. One word moves per cycle.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset `busy_o`, `irq_o` and `sem_o` are 0, and no memory, register or data strobe is active.
- R2: A `start_i` pulse while the channel is idle or halted fetches a descriptor at `start_ptr_i`. The descriptor is four or more consecutive words: word 0 is the link address, word 1 the command word, word 2 the buffer address, and word 3 onward the setup words. The command word fields are: [31:16] byte count, [15:12] setup word count, [8] halt-on-terminate, [7] wait-for-end, [6] semaphore decrement, [3] interrupt enable, [2] chain, [1:0] transfer kind.
- R3: With a setup word count N, descriptor words 3 to 3+N-1 are written in order to peripheral registers 0 to N-1 through `pio_we_o`. With N = 0 no register is written.
- R4: Kind 01 moves ceil(bytes/4) words, each read from the peripheral data port (`pd_rd_o`) and written to the buffer address plus 0, 1, 2 and so on.
- R5: Kind 10 moves ceil(bytes/4) words, reading from the buffer address plus 0, 1, 2 and so on and presenting each word on `pd_wdata_o` with `pd_wr_o`.
- R6: Kinds 00 and 11 move no data. Setup words are still written.
- R7: The byte count is the low COUNT_W bits of the field. A count of zero means 2^COUNT_W bytes.
- R8: When the interrupt enable bit is set, `irq_o` sets when the descriptor completes and stays set until an `irq_clr_i` pulse. A set in the same cycle as a clear wins. When the bit is clear, completion leaves `irq_o` unchanged.
- R9: When the chain bit is set, the channel fetches the next descriptor from the link address after completion. When it is clear, the channel goes idle and `busy_o` drops.
- R10: When the wait-for-end bit is set on a chained descriptor, the channel does not fetch the next descriptor until `end_cmd_i` is seen.
- R11: When the semaphore bit is set, the semaphore decrements at completion and does not go below 0. A chained channel whose semaphore is then 0 stalls until it becomes nonzero. `sem_inc_i` adds `sem_inc_amt_i`, and the sum saturates at 2^SEM_W-1.
- R12: `term_i` during the setup-word or data phase of a descriptor with halt-on-terminate set stops it at once. No word moves in that cycle, and there is no interrupt, semaphore decrement or chaining. `busy_o` drops, and a later `start_i` restarts the channel.
- R13: `term_i` during the setup-word or data phase of a descriptor with halt-on-terminate clear stops the transfer at once. Completion then proceeds normally: interrupt, semaphore, wait-for-end and chain are all honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch the channel at `start_ptr_i` |
| start_ptr_i | input | 32 | Word address of the first descriptor |
| term_i | input | 1 | Terminate the current descriptor |
| end_cmd_i | input | 1 | Peripheral end-of-command indication |
| sem_inc_i | input | 1 | Semaphore increment strobe |
| sem_inc_amt_i | input | SEM_W | Semaphore increment amount |
| irq_clr_i | input | 1 | Clear the interrupt status |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the request cycle |
| pio_we_o | output | 1 | Peripheral register write strobe |
| pio_addr_o | output | PIO_AW | Peripheral register index |
| pio_wdata_o | output | 32 | Peripheral register write data |
| pd_rd_o | output | 1 | Peripheral data read strobe |
| pd_rdata_i | input | 32 | Peripheral data read value |
| pd_wr_o | output | 1 | Peripheral data write strobe |
| pd_wdata_o | output | 32 | Peripheral data write value |
| irq_o | output | 1 | Sticky interrupt status |
| sem_o | output | SEM_W | Current semaphore count |
| busy_o | output | 1 | Channel is processing or stalled |

## Verification
The bench builds the channel with COUNT_W = 8 and keeps SEM_W = 8 and PIO_AW = 4. The narrow count makes a zero byte count mean 256 bytes, a 64-word transfer that finishes in well under a hundred cycles. This brings the zero-count wrap and the terminate-mid-transfer cases within reach of a short run. The 8-bit semaphore lets two increments of 200 reach saturation directly.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        XF_NONE      = 2'b00,
        XF_TO_MEM    = 2'b01,
        XF_TO_PERIPH = 2'b10,
        XF_RSVD      = 2'b11
    } xfer_e;

    // Command word, MSB first
    typedef struct packed {
        logic [15:0] nbytes;
        logic [3:0]  npio;
        logic [2:0]  rsv_hi;
        logic        halt_term;
        logic        wait_end;
        logic        sem_dec;
        logic [1:0]  rsv_lo;
        logic        irq_en;
        logic        chain;
        xfer_e       kind;
    } cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_NXT,
        S_FETCH_CMD,
        S_FETCH_BUF,
        S_PIO,
        S_XFER,
        S_DONE,
        S_WAIT_END,
        S_SEM_WAIT,
        S_HALT
    } st_e;

    function automatic logic moves_data(xfer_e k);
        return (k == XF_TO_MEM) || (k == XF_TO_PERIPH);
    endfunction

    function automatic logic is_parked(st_e s);
        return (s == S_IDLE) || (s == S_HALT);
    endfunction

endpackage

// File: rtl/dma_seq_sem.sv
module dma_seq_sem #(
    parameter int SEM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic [SEM_W-1:0] inc_amt_i,
    input  logic             dec_i,
    output logic [SEM_W-1:0] cnt_o,
    output logic             nz_o
);
    localparam logic [SEM_W-1:0] SEM_MAX = '1;

    logic [SEM_W-1:0] cnt_q;
    logic [SEM_W-1:0] after_dec;
    logic [SEM_W:0]   sum;

    always_comb begin
        after_dec = (dec_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        sum       = {1'b0, after_dec} + {1'b0, (inc_i ? inc_amt_i : '0)};
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= sum[SEM_W] ? SEM_MAX : sum[SEM_W-1:0];
    end

    assign cnt_o = cnt_q;
    assign nz_o  = (cnt_q != '0);

    // R11: a lone decrement of a nonzero count lowers it by exactly one
    p_sem_dec_r11: assert property (@(posedge clk) disable iff (rst)
        dec_i && !inc_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

    // R11: a lone increment from the maximum stays at the maximum
    p_sem_sat_r11: assert property (@(posedge clk) disable iff (rst)
        inc_i && !dec_i && cnt_q == SEM_MAX |=> cnt_q == SEM_MAX);

endmodule

// File: rtl/dma_seq_irq.sv
module dma_seq_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)        irq_q <= 1'b0;
        else if (set_i) irq_q <= 1'b1;
        else if (clr_i) irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // R8: status stays set without a clear
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq_q && !clr_i |=> irq_q);

    // R8: a set is always visible next cycle, even against a clear
    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> irq_q);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int COUNT_W = 16,
    parameter int PIO_AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] start_ptr_i,
    input  logic              term_i,
    input  logic              end_cmd_i,
    input  logic              sem_nz_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              pio_we_o,
    output logic [PIO_AW-1:0] pio_addr_o,
    output logic [WORD_W-1:0] pio_wdata_o,
    output logic              pd_rd_o,
    input  logic [WORD_W-1:0] pd_rdata_i,
    output logic              pd_wr_o,
    output logic [WORD_W-1:0] pd_wdata_o,
    output logic              irq_set_o,
    output logic              sem_dec_o,
    output logic              busy_o
);
    localparam int WCNT_W = COUNT_W + 1;

    st_e               st_q, st_d;
    logic [WORD_W-1:0] desc_q, nxt_q, buf_q;
    cmd_t              cmd_q;
    logic [3:0]        pio_idx_q;
    logic [WCNT_W-1:0] idx_q;

    logic [COUNT_W-1:0] nbytes_f;
    logic [WCNT_W-1:0]  bytes_all, words_all;
    logic               last_word, last_pio, term_hit, launch, follow;
    logic               unused_cmd;

    assign unused_cmd = ^{cmd_q.rsv_hi, cmd_q.rsv_lo, cmd_q.nbytes};

    always_comb begin
        nbytes_f  = cmd_q.nbytes[COUNT_W-1:0];
        bytes_all = (nbytes_f == '0) ? {1'b1, {COUNT_W{1'b0}}} : {1'b0, nbytes_f};
        words_all = (bytes_all + WCNT_W'(3)) >> 2;
        last_word = (idx_q == words_all - 1'b1);
        last_pio  = (pio_idx_q == cmd_q.npio - 4'd1);
        term_hit  = term_i && (st_q == S_PIO || st_q == S_XFER);
    end

    always_comb begin
        st_d        = st_q;
        launch      = 1'b0;
        follow      = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        pio_we_o    = 1'b0;
        pio_addr_o  = '0;
        pio_wdata_o = '0;
        pd_rd_o     = 1'b0;
        pd_wr_o     = 1'b0;
        pd_wdata_o  = '0;
        irq_set_o   = 1'b0;
        sem_dec_o   = 1'b0;
        unique case (st_q)
            S_IDLE, S_HALT: begin
                if (start_i) begin
                    launch = 1'b1;
                    st_d   = S_FETCH_NXT;
                end
            end
            S_FETCH_NXT: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q;
                st_d       = S_FETCH_CMD;
            end
            S_FETCH_CMD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + WORD_W'(1);
                st_d       = S_FETCH_BUF;
            end
            S_FETCH_BUF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + WORD_W'(2);
                if (cmd_q.npio != '0)          st_d = S_PIO;
                else if (moves_data(cmd_q.kind)) st_d = S_XFER;
                else                           st_d = S_DONE;
            end
            S_PIO: begin
                if (term_hit) begin
                    st_d = cmd_q.halt_term ? S_HALT : S_DONE;
                end else begin
                    mem_req_o   = 1'b1;
                    mem_addr_o  = desc_q + WORD_W'(3) + WORD_W'(pio_idx_q);
                    pio_we_o    = 1'b1;
                    pio_addr_o  = PIO_AW'(pio_idx_q);
                    pio_wdata_o = mem_rdata_i;
                    if (last_pio) st_d = moves_data(cmd_q.kind) ? S_XFER : S_DONE;
                end
            end
            S_XFER: begin
                if (term_hit) begin
                    st_d = cmd_q.halt_term ? S_HALT : S_DONE;
                end else begin
                    mem_req_o  = 1'b1;
                    mem_addr_o = buf_q + WORD_W'(idx_q);
                    if (cmd_q.kind == XF_TO_MEM) begin
                        mem_we_o    = 1'b1;
                        mem_wdata_o = pd_rdata_i;
                        pd_rd_o     = 1'b1;
                    end else begin
                        pd_wr_o    = 1'b1;
                        pd_wdata_o = mem_rdata_i;
                    end
                    if (last_word) st_d = S_DONE;
                end
            end
            S_DONE: begin
                irq_set_o = cmd_q.irq_en;
                sem_dec_o = cmd_q.sem_dec;
                if (!cmd_q.chain)         st_d = S_IDLE;
                else if (cmd_q.wait_end)  st_d = S_WAIT_END;
                else if (cmd_q.sem_dec)   st_d = S_SEM_WAIT;
                else begin
                    st_d   = S_FETCH_NXT;
                    follow = 1'b1;
                end
            end
            S_WAIT_END: begin
                if (end_cmd_i) begin
                    if (cmd_q.sem_dec) st_d = S_SEM_WAIT;
                    else begin
                        st_d   = S_FETCH_NXT;
                        follow = 1'b1;
                    end
                end
            end
            S_SEM_WAIT: begin
                if (sem_nz_i) begin
                    st_d   = S_FETCH_NXT;
                    follow = 1'b1;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            desc_q    <= '0;
            nxt_q     <= '0;
            buf_q     <= '0;
            cmd_q     <= '0;
            pio_idx_q <= '0;
            idx_q     <= '0;
        end else begin
            st_q <= st_d;
            if (launch)      desc_q <= start_ptr_i;
            else if (follow) desc_q <= nxt_q;
            if (st_q == S_FETCH_NXT) nxt_q <= mem_rdata_i;
            if (st_q == S_FETCH_CMD) cmd_q <= cmd_t'(mem_rdata_i);
            if (st_q == S_FETCH_BUF) begin
                buf_q     <= mem_rdata_i;
                pio_idx_q <= '0;
                idx_q     <= '0;
            end
            if (st_q == S_PIO && !term_hit)  pio_idx_q <= pio_idx_q + 4'd1;
            if (st_q == S_XFER && !term_hit) idx_q <= idx_q + 1'b1;
        end
    end

    assign busy_o = !is_parked(st_q);

    // R3: back-to-back register writes step through consecutive indices
    p_pio_seq_r3: assert property (@(posedge clk) disable iff (rst)
        pio_we_o && $past(pio_we_o) |-> pio_addr_o == PIO_AW'($past(pio_addr_o) + 1'b1));

    // R4: consecutive data-phase accesses walk the buffer upward by one word
    p_xfer_addr_r4: assert property (@(posedge clk) disable iff (rst)
        st_q == S_XFER && $past(st_q) == S_XFER && mem_req_o && $past(mem_req_o)
        |-> mem_addr_o == $past(mem_addr_o) + WORD_W'(1));

    // R10: no progress past the wait point without end-of-command
    p_wait_end_r10: assert property (@(posedge clk) disable iff (rst)
        st_q == S_WAIT_END && !end_cmd_i |=> st_q == S_WAIT_END && !mem_req_o);

    // R11: a stalled channel issues no memory traffic
    p_sem_stall_r11: assert property (@(posedge clk) disable iff (rst)
        st_q == S_SEM_WAIT && !sem_nz_i |=> !mem_req_o);

    // R12: halting terminate parks the channel on the next cycle
    p_halt_r12: assert property (@(posedge clk) disable iff (rst)
        term_hit && cmd_q.halt_term |=> !busy_o && !irq_set_o && !sem_dec_o);

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int COUNT_W = 16,
    parameter int SEM_W   = 8,
    parameter int PIO_AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [31:0]       start_ptr_i,
    input  logic              term_i,
    input  logic              end_cmd_i,
    input  logic              sem_inc_i,
    input  logic [SEM_W-1:0]  sem_inc_amt_i,
    input  logic              irq_clr_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    output logic              pio_we_o,
    output logic [PIO_AW-1:0] pio_addr_o,
    output logic [31:0]       pio_wdata_o,
    output logic              pd_rd_o,
    input  logic [31:0]       pd_rdata_i,
    output logic              pd_wr_o,
    output logic [31:0]       pd_wdata_o,
    output logic              irq_o,
    output logic [SEM_W-1:0]  sem_o,
    output logic              busy_o
);
    logic irq_set, sem_dec, sem_nz;

    dma_seq_fsm #(
        .COUNT_W (COUNT_W),
        .PIO_AW  (PIO_AW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_ptr_i (start_ptr_i),
        .term_i      (term_i),
        .end_cmd_i   (end_cmd_i),
        .sem_nz_i    (sem_nz),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .pio_we_o    (pio_we_o),
        .pio_addr_o  (pio_addr_o),
        .pio_wdata_o (pio_wdata_o),
        .pd_rd_o     (pd_rd_o),
        .pd_rdata_i  (pd_rdata_i),
        .pd_wr_o     (pd_wr_o),
        .pd_wdata_o  (pd_wdata_o),
        .irq_set_o   (irq_set),
        .sem_dec_o   (sem_dec),
        .busy_o      (busy_o)
    );

    dma_seq_sem #(.SEM_W(SEM_W)) u_sem (
        .clk       (clk),
        .rst       (rst),
        .inc_i     (sem_inc_i),
        .inc_amt_i (sem_inc_amt_i),
        .dec_i     (sem_dec),
        .cnt_o     (sem_o),
        .nz_o      (sem_nz)
    );

    dma_seq_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .set_i (irq_set),
        .clr_i (irq_clr_i),
        .irq_o (irq_o)
    );

    // R1: the channel is quiet while parked
    p_parked_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o && !pio_we_o && !pd_rd_o && !pd_wr_o);

endmodule

// File: tb/tb_dma_seq_chan.sv
`timescale 1ns/1ps
module tb_dma_seq_chan;
    localparam int CW = 8;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        start = 0, term = 0, end_cmd = 0, sem_inc = 0, irq_clr = 0;
    logic [31:0] start_ptr = 0;
    logic [7:0]  sem_amt = 0;
    logic        mem_req, mem_we, pio_we, pd_rd, pd_wr, irq, busy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pio_wdata, pd_rdata, pd_wdata;
    logic [3:0]  pio_addr;
    logic [7:0]  sem;

    logic [31:0] mem     [0:1023];
    logic [31:0] pw_log  [0:1023];
    logic [31:0] pio_reg [0:15];
    int unsigned rd_cnt = 0, pw_cnt = 0, pio_cnt = 0;
    int checks = 0, errs = 0;

    function automatic logic [31:0] pat(int unsigned n);
        return 32'h5A00_0000 ^ (n * 32'h0001_0203);
    endfunction
    function automatic logic [31:0] pio_val(int a, int i);
        return 32'hC0DE_0000 | (32'(a) << 8) | 32'(i);
    endfunction
    function automatic int nwords(int bytes);
        int b = (bytes == 0) ? (1 << CW) : bytes;
        return (b + 3) / 4;
    endfunction
    function automatic logic [31:0] mk_cmd(int bytes, int npio, bit halt, bit wt,
                                           bit sd, bit ie, bit ch, int kind);
        return {16'(bytes), 4'(npio), 3'b0, halt, wt, sd, 2'b0, ie, ch, 2'(kind)};
    endfunction

    assign mem_rdata = mem[mem_addr[9:0]];
    assign pd_rdata  = pat(rd_cnt);

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (pio_we) begin
            pio_reg[pio_addr] <= pio_wdata;
            pio_cnt <= pio_cnt + 1;
        end
        if (pd_rd) rd_cnt <= rd_cnt + 1;
        if (pd_wr) begin
            pw_log[pw_cnt[9:0]] <= pd_wdata;
            pw_cnt <= pw_cnt + 1;
        end
    end

    dma_seq_chan #(.COUNT_W(CW), .SEM_W(8), .PIO_AW(4)) dut (
        .clk(clk), .rst(rst), .start_i(start), .start_ptr_i(start_ptr),
        .term_i(term), .end_cmd_i(end_cmd), .sem_inc_i(sem_inc),
        .sem_inc_amt_i(sem_amt), .irq_clr_i(irq_clr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .pio_we_o(pio_we), .pio_addr_o(pio_addr), .pio_wdata_o(pio_wdata),
        .pd_rd_o(pd_rd), .pd_rdata_i(pd_rdata), .pd_wr_o(pd_wr),
        .pd_wdata_o(pd_wdata), .irq_o(irq), .sem_o(sem), .busy_o(busy)
    );

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic put_desc(int a, int nxt, logic [31:0] cmd, int bufp);
        mem[a]     = 32'(nxt);
        mem[a + 1] = cmd;
        mem[a + 2] = 32'(bufp);
        for (int i = 0; i < 15; i++) mem[a + 3 + i] = pio_val(a, i);
    endtask

    task automatic kick(int a);
        @(negedge clk); start = 1; start_ptr = 32'(a);
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        if (g >= 5000) chk(0, "R9 channel stuck busy", 32'(busy), 0);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    task automatic bump_sem(int amt);
        @(negedge clk); sem_inc = 1; sem_amt = 8'(amt);
        @(negedge clk); sem_inc = 0;
    endtask

    // Single unchained descriptor, checked against bench-computed results
    task automatic run_desc(int a, int bytes, int npio, int kind, bit ie);
        int bufp = (kind == 2) ? 512 : 256;
        int nw   = nwords(bytes);
        int unsigned rd0 = rd_cnt, pw0 = pw_cnt;
        int bad = 0;
        put_desc(a, 0, mk_cmd(bytes, npio, 0, 0, 0, ie, 0, kind), bufp);
        for (int k = 0; k < 16; k++) pio_reg[k] = '0;
        if (kind != 2) for (int k = 0; k <= 64; k++) mem[bufp + k] = SENT;
        clear_irq();
        kick(a);
        wait_idle();
        for (int i = 0; i < npio; i++) if (pio_reg[i] !== pio_val(a, i)) bad++;
        if (npio < 16 && pio_reg[npio] !== 0) bad++;
        chk(bad == 0, $sformatf("R3 setup words npio=%0d", npio), 32'(bad), 0);
        bad = 0;
        if (kind == 1) begin
            chk(rd_cnt - rd0 == nw, $sformatf("R4 R7 words read bytes=%0d", bytes),
                rd_cnt - rd0, 32'(nw));
            for (int k = 0; k < nw; k++) if (mem[bufp + k] !== pat(rd0 + k)) bad++;
            if (mem[bufp + nw] !== SENT) bad++;
            chk(bad == 0, "R4 buffer contents", 32'(bad), 0);
        end else if (kind == 2) begin
            chk(pw_cnt - pw0 == nw, $sformatf("R5 R7 words written bytes=%0d", bytes),
                pw_cnt - pw0, 32'(nw));
            for (int k = 0; k < nw; k++)
                if (pw_log[(pw0 + k) % 1024] !== mem[bufp + k]) bad++;
            chk(bad == 0, "R5 peripheral data", 32'(bad), 0);
        end else begin
            chk(rd_cnt == rd0 && pw_cnt == pw0 && mem[bufp] === SENT,
                $sformatf("R6 no movement kind=%0d", kind), rd_cnt - rd0 + pw_cnt - pw0, 0);
        end
        chk(irq == ie, "R8 completion interrupt", 32'(irq), 32'(ie));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired (R9 progress)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        int unsigned pio0, rd0, moved;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 1024; k++) begin mem[k] = $urandom; pw_log[k] = '0; end
        for (int k = 0; k < 16; k++) pio_reg[k] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !irq && sem == 0 && !mem_req && !pio_we && !pd_rd && !pd_wr,
            "R1 reset state", {busy, irq, mem_req, pio_we, pd_rd, pd_wr}, 0);

        // Directed: zero byte count, no setup words, R2 layout
        run_desc(16, 0, 0, 1, 1);
        run_desc(16, 0, 3, 2, 0);
        run_desc(32, 5, 15, 0, 1);
        run_desc(32, 4, 2, 3, 0);

        // Random descriptors
        for (int it = 0; it < 10; it++)
            run_desc(32 * (it % 6), $urandom_range(0, 255), $urandom_range(0, 15),
                     $urandom_range(0, 3), 1'($urandom_range(0, 1)));

        // R8: set persists, clear drops it
        run_desc(0, 8, 0, 0, 1);
        repeat (5) @(negedge clk);
        chk(irq == 1, "R8 status sticky", 32'(irq), 1);
        clear_irq();
        chk(irq == 0, "R8 clear", 32'(irq), 0);

        // R9 R2: chain A->B->C, C unchained, D must not run
        put_desc(0,   32, mk_cmd(4, 1, 0, 0, 0, 0, 1, 0), 256);
        put_desc(32,  64, mk_cmd(4, 1, 0, 0, 0, 0, 1, 0), 256);
        put_desc(64,  96, mk_cmd(4, 1, 0, 0, 0, 0, 0, 0), 256);
        put_desc(96,   0, mk_cmd(4, 2, 0, 0, 0, 0, 0, 0), 256);
        pio0 = pio_cnt;
        kick(0); wait_idle();
        chk(pio_cnt - pio0 == 3, "R9 chained descriptor count", pio_cnt - pio0, 3);
        chk(pio_reg[0] === pio_val(64, 0), "R2 R9 last descriptor link", pio_reg[0], pio_val(64, 0));

        // R10: wait for end-of-command before chaining
        put_desc(0,  32, mk_cmd(4, 1, 0, 1, 0, 0, 1, 0), 256);
        put_desc(32,  0, mk_cmd(4, 1, 0, 0, 0, 0, 0, 0), 256);
        pio0 = pio_cnt;
        kick(0);
        repeat (60) @(negedge clk);
        chk(busy && pio_cnt - pio0 == 1, "R10 held before end-of-command", pio_cnt - pio0, 1);
        end_cmd = 1; @(negedge clk); end_cmd = 0;
        wait_idle();
        chk(pio_cnt - pio0 == 2, "R10 resumed after end-of-command", pio_cnt - pio0, 2);

        // R11: semaphore stall and release
        bump_sem(1);
        chk(sem == 1, "R11 increment", 32'(sem), 1);
        put_desc(0,  32, mk_cmd(4, 1, 0, 0, 1, 0, 1, 0), 256);
        put_desc(32,  0, mk_cmd(4, 1, 0, 0, 0, 0, 0, 0), 256);
        pio0 = pio_cnt;
        kick(0);
        repeat (60) @(negedge clk);
        chk(busy && sem == 0 && pio_cnt - pio0 == 1, "R11 stalled at zero", {sem, 8'(pio_cnt - pio0)}, 32'h0001);
        bump_sem(2);
        wait_idle();
        chk(pio_cnt - pio0 == 2 && sem == 2, "R11 released", {sem, 8'(pio_cnt - pio0)}, 32'h0202);
        bump_sem(200);
        bump_sem(200);
        chk(sem == 255, "R11 saturation", 32'(sem), 255);
        put_desc(0, 0, mk_cmd(4, 0, 0, 0, 1, 0, 0, 0), 256);
        kick(0); wait_idle();
        chk(sem == 254 && !busy, "R11 decrement unchained", 32'(sem), 254);

        // R12 / R13: terminate mid-transfer with and without halt
        for (int h = 1; h >= 0; h--) begin
            put_desc(0,  32, mk_cmd(0, 0, 1'(h), 0, 0, 1, 1, 1), 256);
            put_desc(32,  0, mk_cmd(4, 1, 0, 0, 0, 0, 0, 0), 256);
            clear_irq();
            pio0 = pio_cnt;
            rd0 = rd_cnt;
            kick(0);
            while (rd_cnt - rd0 < 5) @(negedge clk);
            term = 1; @(negedge clk); term = 0;
            wait_idle();
            moved = rd_cnt - rd0;
            if (h == 1) begin
                chk(moved == 5, "R12 stopped at once", moved, 5);
                chk(!irq && pio_cnt == pio0, "R12 no completion actions", {irq, 8'(pio_cnt - pio0)}, 0);
                kick(32); wait_idle();
                chk(pio_cnt - pio0 == 1, "R12 restart after halt", pio_cnt - pio0, 1);
            end else begin
                chk(moved == 5, "R13 stopped at once", moved, 5);
                chk(irq && pio_cnt - pio0 == 1 && pio_reg[0] === pio_val(32, 0),
                    "R13 completion honoured", {irq, 8'(pio_cnt - pio0)}, 32'h101);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule